// File: doc/BRIEF.md
# Bridge Address Window Decoder

This block decides whether a transaction seen on the primary side of a bus-to-bus bridge should be passed to the secondary bus. It takes the bridge's configuration fields as plain inputs: base and limit for one I/O window, one non-prefetchable memory window and one prefetchable memory window, plus the two space-enable bits of the command register and the legacy-display enable of the bridge control register. From these it rebuilds each window's full address bounds and compares the transaction address against them.

For every cycle it reports whether to forward the transaction, and which decode matched. It also reports the rebuilt base and limit of each window so that the bounds can be observed. All outputs are registered, so a result appears one clock after its inputs. A configuration change therefore applies to the address that is presented together with it. Bus protocol handling, the configuration access path and data movement belong to other blocks.

Top module: `bridge_window_decoder`

## Requirements
- R1: Reset is synchronous and active high. While it is asserted, every output is zero at the next clock edge. Otherwise every output reflects the inputs sampled at the previous clock edge.
- R2: The I/O base is built as address bits 15:12 = base field bits 7:4, with bits 11:0 zero. The I/O limit is built the same way from its own field, but with bits 11:0 all ones. If bit 0 of a field is 0, bits 31:16 of that bound are zero and its upper-16 input is ignored.
- R3: If bit 0 of an I/O base or limit field is 1, that bound takes its address bits 31:16 from its 16-bit upper input.
- R4: The memory bounds take address bits 31:20 from bits 15:4 of their 16-bit fields. Bits 3:0 of these fields are ignored. The base has its low 20 bits zero and the limit has its low 20 bits all ones. Address bits 63:32 of both bounds are zero.
- R5: The prefetchable bounds use the same layout as the memory bounds. If bit 0 of a prefetchable field is 1, that bound takes address bits 63:32 from its 32-bit upper input. If bit 0 is 0, those bits are zero.
- R6: A window hits when base ≤ address ≤ limit, both ends included. An I/O request (`req_is_io`=1) is compared using `req_addr[31:0]` against the I/O window only. A memory request is compared at the full 64 bits against the two memory windows only.
- R7: A window whose limit is below its base never hits.
- R8: The I/O window hits only when `cmd_io_en` is 1. The two memory windows hit only when `cmd_mem_en` is 1.
- R9: When `vga_en` is 1, the legacy display ranges hit. For memory requests this is 0xA0000–0xBFFFF. For I/O requests it is 0x3B0–0x3BB and 0x3C0–0x3DF, matched on address bits 9:0 only. When `vga_en` is 0, they never hit.
- R10: `hit_vec` is one-hot or zero, with bit 0 = I/O window, bit 1 = memory window, bit 2 = prefetchable window and bit 3 = legacy display. When more than one decode matches, priority for memory requests is prefetchable, then memory, then legacy display. For I/O requests it is the I/O window, then legacy display.
- R11: `fwd` is 1 exactly when `hit_vec` is nonzero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_io_en | input | 1 | Command register I/O space enable |
| cmd_mem_en | input | 1 | Command register memory space enable |
| vga_en | input | 1 | Bridge control legacy display enable |
| io_base_fld | input | 8 | I/O base field (bit 0 selects 32-bit) |
| io_limit_fld | input | 8 | I/O limit field (bit 0 selects 32-bit) |
| io_base_hi | input | 16 | I/O base upper 16 bits |
| io_limit_hi | input | 16 | I/O limit upper 16 bits |
| mem_base_fld | input | 16 | Memory base field |
| mem_limit_fld | input | 16 | Memory limit field |
| pf_base_fld | input | 16 | Prefetchable base field (bit 0 selects 64-bit) |
| pf_limit_fld | input | 16 | Prefetchable limit field (bit 0 selects 64-bit) |
| pf_base_hi | input | 32 | Prefetchable base upper 32 bits |
| pf_limit_hi | input | 32 | Prefetchable limit upper 32 bits |
| req_is_io | input | 1 | 1 = I/O request, 0 = memory request |
| req_addr | input | 64 | Request address |
| fwd | output | 1 | Forward to secondary bus |
| hit_vec | output | 4 | One-hot decode result |
| io_base_q | output | 32 | Rebuilt I/O base |
| io_limit_q | output | 32 | Rebuilt I/O limit |
| mem_base_q | output | 32 | Rebuilt memory base |
| mem_limit_q | output | 32 | Rebuilt memory limit |
| pf_base_q | output | 64 | Rebuilt prefetchable base |
| pf_limit_q | output | 64 | Rebuilt prefetchable limit |

## Verification
There is no stored state beyond the single output register stage. A fault in how a bound is rebuilt therefore shows up on the matching `*_q` output one clock after the field is applied. It also shows up on `hit_vec` at the same moment, for addresses just inside or just outside that bound. A fault in priority or gating shows as a wrong or multiple `hit_vec` bit, or as `fwd` disagreeing with it, on the very next cycle. For this reason the probes sit on exact window edges, on overlapping windows and on gated-off windows.

// File: rtl/bwd_pkg.sv
package bwd_pkg;
  localparam int ADDR_W   = 64;
  localparam int IO_W     = 32;
  localparam int IO_GRAN  = 12;
  localparam int MEM_GRAN = 20;
  localparam int HIT_IO   = 0;
  localparam int HIT_MEM  = 1;
  localparam int HIT_PF   = 2;
  localparam int HIT_VGA  = 3;
  localparam int HIT_N    = 4;
  localparam logic [ADDR_W-1:0] VGA_MEM_LO = 64'h0000_0000_000A_0000;
  localparam logic [ADDR_W-1:0] VGA_MEM_HI = 64'h0000_0000_000B_FFFF;
  localparam logic [9:0] VGA_IO_A_LO = 10'h3B0;
  localparam logic [9:0] VGA_IO_A_HI = 10'h3BB;
  localparam logic [9:0] VGA_IO_B_LO = 10'h3C0;
  localparam logic [9:0] VGA_IO_B_HI = 10'h3DF;
endpackage

// File: rtl/bwd_io_window.sv
module bwd_io_window
  import bwd_pkg::*;
#(
  parameter int AW   = IO_W,
  parameter int GRAN = IO_GRAN
) (
  input  logic [7:0]    base_fld,
  input  logic [7:0]    limit_fld,
  input  logic [15:0]   base_hi,
  input  logic [15:0]   limit_hi,
  input  logic          en,
  input  logic          req_io,
  input  logic [AW-1:0] addr,
  output logic [AW-1:0] base,
  output logic [AW-1:0] limit,
  output logic          hit
);
  localparam int HI_W = AW - 16;

  function automatic logic [AW-1:0] build(input logic [7:0] fld,
                                          input logic [15:0] hi,
                                          input logic fill);
    logic [AW-1:0] v;
    v = '0;
    v[15:GRAN] = fld[7:4];
    v[GRAN-1:0] = {GRAN{fill}};
    if (fld[0]) v[AW-1:16] = hi[HI_W-1:0];
    return v;
  endfunction

  always_comb begin
    base  = build(base_fld, base_hi, 1'b0);
    limit = build(limit_fld, limit_hi, 1'b1);
    hit   = en && req_io && (limit >= base) && (addr >= base) && (addr <= limit);
  end
endmodule

// File: rtl/bwd_mem_window.sv
module bwd_mem_window
  import bwd_pkg::*;
#(
  parameter int AW   = ADDR_W,
  parameter int GRAN = MEM_GRAN,
  parameter bit WIDE = 1'b0
) (
  input  logic [15:0]   base_fld,
  input  logic [15:0]   limit_fld,
  input  logic [31:0]   base_hi,
  input  logic [31:0]   limit_hi,
  input  logic          en,
  input  logic          req_mem,
  input  logic [AW-1:0] addr,
  output logic [AW-1:0] base,
  output logic [AW-1:0] limit,
  output logic          hit
);
  logic [AW-1:0] base_lo, limit_lo;

  always_comb begin
    base_lo  = '0;
    limit_lo = '0;
    base_lo[31:GRAN]   = base_fld[15:4];
    limit_lo[31:GRAN]  = limit_fld[15:4];
    limit_lo[GRAN-1:0] = {GRAN{1'b1}};
  end

  generate
    if (WIDE) begin : g_wide
      always_comb begin
        base  = base_lo;
        limit = limit_lo;
        if (base_fld[0])  base[AW-1:32]  = base_hi;
        if (limit_fld[0]) limit[AW-1:32] = limit_hi;
      end
    end else begin : g_narrow
      always_comb begin
        base  = base_lo;
        limit = limit_lo;
      end
    end
  endgenerate

  always_comb
    hit = en && req_mem && (limit >= base) && (addr >= base) && (addr <= limit);
endmodule

// File: rtl/bwd_vga_decode.sv
module bwd_vga_decode
  import bwd_pkg::*;
(
  input  logic              en,
  input  logic              req_io,
  input  logic [ADDR_W-1:0] addr,
  output logic              hit
);
  logic [9:0] a10;
  logic       io_hit, mem_hit;

  always_comb begin
    a10     = addr[9:0];
    io_hit  = ((a10 >= VGA_IO_A_LO) && (a10 <= VGA_IO_A_HI)) ||
              ((a10 >= VGA_IO_B_LO) && (a10 <= VGA_IO_B_HI));
    mem_hit = (addr >= VGA_MEM_LO) && (addr <= VGA_MEM_HI);
    hit     = en && (req_io ? io_hit : mem_hit);
  end
endmodule

// File: rtl/bridge_window_decoder.sv
module bridge_window_decoder
  import bwd_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              cmd_io_en,
  input  logic              cmd_mem_en,
  input  logic              vga_en,
  input  logic [7:0]        io_base_fld,
  input  logic [7:0]        io_limit_fld,
  input  logic [15:0]       io_base_hi,
  input  logic [15:0]       io_limit_hi,
  input  logic [15:0]       mem_base_fld,
  input  logic [15:0]       mem_limit_fld,
  input  logic [15:0]       pf_base_fld,
  input  logic [15:0]       pf_limit_fld,
  input  logic [31:0]       pf_base_hi,
  input  logic [31:0]       pf_limit_hi,
  input  logic              req_is_io,
  input  logic [ADDR_W-1:0] req_addr,
  output logic              fwd,
  output logic [HIT_N-1:0]  hit_vec,
  output logic [IO_W-1:0]   io_base_q,
  output logic [IO_W-1:0]   io_limit_q,
  output logic [31:0]       mem_base_q,
  output logic [31:0]       mem_limit_q,
  output logic [ADDR_W-1:0] pf_base_q,
  output logic [ADDR_W-1:0] pf_limit_q
);
  logic [IO_W-1:0]   io_base, io_limit;
  logic [ADDR_W-1:0] mem_base, mem_limit, pf_base, pf_limit;
  logic              io_hit, mem_hit, pf_hit, vga_hit;
  logic [HIT_N-1:0]  sel;

  bwd_io_window u_io (
    .base_fld (io_base_fld),  .limit_fld (io_limit_fld),
    .base_hi  (io_base_hi),   .limit_hi  (io_limit_hi),
    .en       (cmd_io_en),    .req_io    (req_is_io),
    .addr     (req_addr[IO_W-1:0]),
    .base     (io_base),      .limit     (io_limit),
    .hit      (io_hit)
  );

  bwd_mem_window #(.WIDE(1'b0)) u_mem (
    .base_fld (mem_base_fld), .limit_fld (mem_limit_fld),
    .base_hi  (32'h0),        .limit_hi  (32'h0),
    .en       (cmd_mem_en),   .req_mem   (!req_is_io),
    .addr     (req_addr),
    .base     (mem_base),     .limit     (mem_limit),
    .hit      (mem_hit)
  );

  bwd_mem_window #(.WIDE(1'b1)) u_pf (
    .base_fld (pf_base_fld),  .limit_fld (pf_limit_fld),
    .base_hi  (pf_base_hi),   .limit_hi  (pf_limit_hi),
    .en       (cmd_mem_en),   .req_mem   (!req_is_io),
    .addr     (req_addr),
    .base     (pf_base),      .limit     (pf_limit),
    .hit      (pf_hit)
  );

  bwd_vga_decode u_vga (
    .en     (vga_en),
    .req_io (req_is_io),
    .addr   (req_addr),
    .hit    (vga_hit)
  );

  always_comb begin
    sel = '0;
    if (io_hit)       sel[HIT_IO]  = 1'b1;
    else if (pf_hit)  sel[HIT_PF]  = 1'b1;
    else if (mem_hit) sel[HIT_MEM] = 1'b1;
    else if (vga_hit) sel[HIT_VGA] = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      fwd         <= 1'b0;
      hit_vec     <= '0;
      io_base_q   <= '0;
      io_limit_q  <= '0;
      mem_base_q  <= '0;
      mem_limit_q <= '0;
      pf_base_q   <= '0;
      pf_limit_q  <= '0;
    end else begin
      fwd         <= io_hit | mem_hit | pf_hit | vga_hit;
      hit_vec     <= sel;
      io_base_q   <= io_base;
      io_limit_q  <= io_limit;
      mem_base_q  <= mem_base[31:0];
      mem_limit_q <= mem_limit[31:0];
      pf_base_q   <= pf_base;
      pf_limit_q  <= pf_limit;
    end
  end
endmodule

// File: rtl/bridge_window_decoder_chk.sv
module bridge_window_decoder_chk (
  input logic        clk,
  input logic        rst,
  input logic        cmd_io_en,
  input logic        cmd_mem_en,
  input logic        vga_en,
  input logic        fwd,
  input logic [3:0]  hit_vec,
  input logic [31:0] io_base_q,
  input logic [31:0] io_limit_q,
  input logic [31:0] mem_base_q,
  input logic [31:0] mem_limit_q,
  input logic [63:0] pf_base_q,
  input logic [63:0] pf_limit_q
);
  a_r1_clear_after_reset: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (hit_vec == 4'h0 && !fwd));
  a_r10_onehot: assert property (@(posedge clk) disable iff (rst)
    $onehot0(hit_vec));
  a_r11_fwd_matches: assert property (@(posedge clk) disable iff (rst)
    fwd == (hit_vec != 4'h0));
  a_r8_io_gate: assert property (@(posedge clk) disable iff (rst)
    !$past(cmd_io_en) |-> !hit_vec[0]);
  a_r8_mem_gate: assert property (@(posedge clk) disable iff (rst)
    !$past(cmd_mem_en) |-> (!hit_vec[1] && !hit_vec[2]));
  a_r9_vga_gate: assert property (@(posedge clk) disable iff (rst)
    !$past(vga_en) |-> !hit_vec[3]);
  a_r7_io_nonempty: assert property (@(posedge clk) disable iff (rst)
    hit_vec[0] |-> io_base_q <= io_limit_q);
  a_r7_mem_nonempty: assert property (@(posedge clk) disable iff (rst)
    hit_vec[1] |-> mem_base_q <= mem_limit_q);
  a_r7_pf_nonempty: assert property (@(posedge clk) disable iff (rst)
    hit_vec[2] |-> pf_base_q <= pf_limit_q);
endmodule

bind bridge_window_decoder bridge_window_decoder_chk i_chk (
  .clk(clk), .rst(rst), .cmd_io_en(cmd_io_en), .cmd_mem_en(cmd_mem_en),
  .vga_en(vga_en), .fwd(fwd), .hit_vec(hit_vec),
  .io_base_q(io_base_q), .io_limit_q(io_limit_q),
  .mem_base_q(mem_base_q), .mem_limit_q(mem_limit_q),
  .pf_base_q(pf_base_q), .pf_limit_q(pf_limit_q)
);

// File: tb/test_bridge_window_decoder.sv
module test_bridge_window_decoder;
  logic clk = 1'b0, rst = 1'b1;
  logic cmd_io_en, cmd_mem_en, vga_en, req_is_io;
  logic [7:0]  io_base_fld, io_limit_fld;
  logic [15:0] io_base_hi, io_limit_hi, mem_base_fld, mem_limit_fld;
  logic [15:0] pf_base_fld, pf_limit_fld;
  logic [31:0] pf_base_hi, pf_limit_hi;
  logic [63:0] req_addr;
  logic        fwd;
  logic [3:0]  hit_vec;
  logic [31:0] io_base_q, io_limit_q, mem_base_q, mem_limit_q;
  logic [63:0] pf_base_q, pf_limit_q;
  int n_chk = 0, n_fail = 0;
  bit done = 0;

  always #2 clk = ~clk;

  bridge_window_decoder i_bridge_window_decoder (.*);

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic clear_cfg();
    cmd_io_en = 0; cmd_mem_en = 0; vga_en = 0; req_is_io = 0; req_addr = '0;
    io_base_fld = 8'hF0; io_limit_fld = 8'h00; io_base_hi = 0; io_limit_hi = 0;
    mem_base_fld = 16'hFFF0; mem_limit_fld = 16'h0000;
    pf_base_fld = 16'hFFF0; pf_limit_fld = 16'h0000; pf_base_hi = 0; pf_limit_hi = 0;
  endtask

  // drive at negedge, one posedge registers, sample at the following negedge
  task automatic probe(input string req, input logic io, input logic [63:0] a,
                       input logic [3:0] exp_hit);
    @(negedge clk);
    req_is_io = io; req_addr = a;
    @(negedge clk);
    chk(req, {60'h0, hit_vec}, {60'h0, exp_hit});
    chk("R11 fwd", {63'h0, fwd}, {63'h0, exp_hit != 0});
  endtask

  task automatic t_reset();
    @(negedge clk);
    rst = 1; io_base_fld = 8'h21; mem_base_fld = 16'h1230; cmd_mem_en = 1; req_addr = 64'h1230_0000;
    @(negedge clk);
    chk("R1 hit_vec in reset", {60'h0, hit_vec}, 64'h0);
    chk("R1 io_base_q in reset", {32'h0, io_base_q}, 64'h0);
    chk("R1 mem_base_q in reset", {32'h0, mem_base_q}, 64'h0);
    chk("R1 pf_limit_q in reset", pf_limit_q, 64'h0);
    rst = 0; clear_cfg();
  endtask

  task automatic t_io16();
    clear_cfg(); cmd_io_en = 1;
    io_base_fld = 8'h20; io_limit_fld = 8'h40; io_base_hi = 16'h1234; io_limit_hi = 16'h1234;
    probe("R6 io low edge", 1, 64'h2000, 4'b0001);
    chk("R2 io base", {32'h0, io_base_q}, 64'h0000_2000);
    chk("R2 io limit", {32'h0, io_limit_q}, 64'h0000_4FFF);
    probe("R6 io high edge", 1, 64'h4FFF, 4'b0001);
    probe("R6 io above", 1, 64'h5000, 4'b0000);
    probe("R6 io below", 1, 64'h1FFF, 4'b0000);
    probe("R6 mem request ignores io window", 0, 64'h3000, 4'b0000);
  endtask

  task automatic t_io32();
    clear_cfg(); cmd_io_en = 1;
    io_base_fld = 8'h21; io_limit_fld = 8'h31; io_base_hi = 16'h0001; io_limit_hi = 16'h0002;
    probe("R3 io32 inside", 1, 64'h0001_8000, 4'b0001);
    chk("R3 io32 base", {32'h0, io_base_q}, 64'h0001_2000);
    chk("R3 io32 limit", {32'h0, io_limit_q}, 64'h0002_3FFF);
    probe("R3 io32 below", 1, 64'h0000_8000, 4'b0000);
  endtask

  task automatic t_mem();
    clear_cfg(); cmd_mem_en = 1;
    mem_base_fld = 16'hC00F; mem_limit_fld = 16'hC0F5;
    probe("R4 mem top edge", 0, 64'hC0FF_FFFF, 4'b0010);
    chk("R4 mem base", {32'h0, mem_base_q}, 64'hC000_0000);
    chk("R4 mem limit", {32'h0, mem_limit_q}, 64'hC0FF_FFFF);
    probe("R4 mem above", 0, 64'hC100_0000, 4'b0000);
    probe("R4 mem upper bits set", 0, 64'h1_C000_0000, 4'b0000);
    probe("R6 io request ignores mem window", 1, 64'hC000_0000, 4'b0000);
  endtask

  task automatic t_pref();
    clear_cfg(); cmd_mem_en = 1;
    pf_base_fld = 16'h8001; pf_limit_fld = 16'h8FF1; pf_base_hi = 1; pf_limit_hi = 1;
    probe("R5 pf64 inside", 0, 64'h1_8800_0000, 4'b0100);
    chk("R5 pf64 base", pf_base_q, 64'h1_8000_0000);
    chk("R5 pf64 limit", pf_limit_q, 64'h1_8FFF_FFFF);
    probe("R5 pf64 low 4G misses", 0, 64'h8800_0000, 4'b0000);
    pf_base_fld = 16'h8000; pf_limit_fld = 16'h8FF0;
    probe("R5 pf32 inside", 0, 64'h8000_0000, 4'b0100);
    chk("R5 pf32 base", pf_base_q, 64'h8000_0000);
    chk("R5 pf32 limit", pf_limit_q, 64'h8FFF_FFFF);
  endtask

  task automatic t_empty();
    clear_cfg(); cmd_mem_en = 1; cmd_io_en = 1;
    mem_base_fld = 16'hD000; mem_limit_fld = 16'hC000;
    probe("R7 empty mem at limit", 0, 64'hC000_0000, 4'b0000);
    probe("R7 empty mem at base", 0, 64'hD000_0000, 4'b0000);
    io_base_fld = 8'h50; io_limit_fld = 8'h40;
    probe("R7 empty io", 1, 64'h4800, 4'b0000);
  endtask

  task automatic t_enables();
    clear_cfg();
    mem_base_fld = 16'hC000; mem_limit_fld = 16'hC0F0;
    pf_base_fld = 16'h8000; pf_limit_fld = 16'h8FF0;
    io_base_fld = 8'h20; io_limit_fld = 8'h40;
    probe("R8 mem disabled", 0, 64'hC000_0000, 4'b0000);
    chk("R8 mem bounds still shown", {32'h0, mem_base_q}, 64'hC000_0000);
    probe("R8 pf disabled", 0, 64'h8000_0000, 4'b0000);
    probe("R8 io disabled", 1, 64'h2000, 4'b0000);
    cmd_io_en = 1;
    probe("R8 io re-enabled", 1, 64'h2000, 4'b0001);
  endtask

  task automatic t_vga();
    clear_cfg(); vga_en = 1;
    probe("R9 vga mem low", 0, 64'hA0000, 4'b1000);
    probe("R9 vga mem high", 0, 64'hBFFFF, 4'b1000);
    probe("R9 vga mem above", 0, 64'hC0000, 4'b0000);
    probe("R9 vga io A top", 1, 64'h3BB, 4'b1000);
    probe("R9 vga io gap", 1, 64'h3BC, 4'b0000);
    probe("R9 vga io B top", 1, 64'h3DF, 4'b1000);
    probe("R9 vga io above", 1, 64'h3E0, 4'b0000);
    probe("R9 vga io alias", 1, 64'h7B0, 4'b1000);
    vga_en = 0;
    probe("R9 vga disabled", 0, 64'hA0000, 4'b0000);
  endtask

  task automatic t_priority();
    clear_cfg(); cmd_mem_en = 1; cmd_io_en = 1; vga_en = 1;
    mem_base_fld = 16'hC000; mem_limit_fld = 16'hC0F0;
    pf_base_fld = 16'hC000; pf_limit_fld = 16'hC0F0;
    probe("R10 pf over mem", 0, 64'hC080_0000, 4'b0100);
    mem_base_fld = 16'h0000; mem_limit_fld = 16'h0000;
    probe("R10 mem over vga", 0, 64'hA0000, 4'b0010);
    io_base_fld = 8'h00; io_limit_fld = 8'h00;
    probe("R10 io over vga", 1, 64'h3C0, 4'b0001);
  endtask

  initial begin
    clear_cfg();
    repeat (3) @(negedge clk);
    t_reset();
    t_io16();
    t_io32();
    t_mem();
    t_pref();
    t_empty();
    t_enables();
    t_vga();
    t_priority();
    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule